// File: doc/BRIEF.md
# Abort-on-Invalidate Transaction Tracker

This unit sits beside a private data cache and watches a running hardware-assisted transaction. Software tags individual cache lines as abort-sensitive by line index and can untag them again. If a tagged line leaves the cache for any reason, whether another core's coherence invalidation takes it or a capacity eviction pushes it out, the unit aborts the transaction at once. It reports the abort as a one-cycle pulse carrying the handler address that software registered when the transaction began.

The same abort path also serves an explicit self-abort request and a commit whose status check fails. Commit is a compare-and-swap on a small status-word register that models the transaction's status word in memory. If the word equals the supplied compare value, the new value is written, a success pulse is raised and the cache is told to flash-commit its transactional lines. Every abort also tells the cache to flash-discard them. Both outcomes clear all tags and end the transaction.

The controller has two states. TX_IDLE means no transaction is running. TX_OPEN means a transaction is running and tags are being watched. The transitions are START (TX_IDLE to TX_OPEN on a set-handler request), ABORT (TX_OPEN to TX_IDLE on any abort cause) and COMMIT (TX_OPEN to TX_IDLE on a successful compare-and-swap). TX_OPEN stays in TX_OPEN when none of ABORT or COMMIT occurs.

Top module: `abort_watch_unit`

## Requirements
- R1: After reset the unit is in TX_IDLE, holds no tags, all output pulses are low and `status_word` is 0.
- R2: `set_handler` in TX_IDLE stores `handler_pc`, loads `status_word` with ST_ACTIVE (default 0x01) and enters TX_OPEN. In TX_OPEN, when there is neither an abort nor a commit in that cycle, `set_handler` replaces the stored handler address.
- R3: In TX_OPEN, `mark_valid` tags line `mark_idx` and `release_valid` untags line `release_idx`. Tagging wins when both name the same line. Releasing an untagged line changes nothing. Mark and release requests in TX_IDLE are ignored.
- R4: In TX_OPEN, `inval_valid` naming a tagged line causes an abort, with `abort_valid` high in the following cycle. The check uses the tags held before that cycle.
- R5: In TX_OPEN, `evict_valid` naming a tagged line causes an abort in the same way as R4.
- R6: An invalidation or eviction that names an untagged line never causes an abort.
- R7: `self_abort` in TX_OPEN causes an abort. In TX_IDLE it is ignored.
- R8: `commit_req` in TX_OPEN with `status_word == commit_cmp` and no abort cause writes `commit_new` into `status_word`. In the next cycle it pulses `commit_ok` and `flash_commit` for one cycle, clears all tags and returns to TX_IDLE.
- R9: `commit_req` in TX_OPEN with `status_word != commit_cmp` raises an abort and never `commit_ok`.
- R10: An abort pulses `abort_valid` and `flash_abort` for exactly one cycle, with `abort_pc` equal to the handler address held before that cycle. It also clears all tags, writes ST_ABORTED (default 0x02) into `status_word` and returns to TX_IDLE.
- R11: Any mix of abort causes in one cycle gives exactly one abort pulse. An abort cause in the same cycle as a commit suppresses the commit, leaving `commit_ok` low.
- R12: `commit_req` in TX_IDLE is ignored: no pulse is raised and `status_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_valid | input | 1 | Tag a line as abort-sensitive |
| mark_idx | input | IDX_W | Line to tag |
| release_valid | input | 1 | Untag a line |
| release_idx | input | IDX_W | Line to untag |
| set_handler | input | 1 | Register handler address; starts a transaction from TX_IDLE |
| handler_pc | input | PC_W | Handler address |
| inval_valid | input | 1 | Coherence invalidation of a line |
| inval_idx | input | IDX_W | Invalidated line |
| evict_valid | input | 1 | Capacity eviction of a line |
| evict_idx | input | IDX_W | Evicted line |
| self_abort | input | 1 | Explicit abort request |
| commit_req | input | 1 | Compare-and-swap commit request |
| commit_cmp | input | ST_W | Expected status value |
| commit_new | input | ST_W | Status value written on success |
| abort_valid | output | 1 | One-cycle abort pulse |
| abort_pc | output | PC_W | Handler address for the abort |
| commit_ok | output | 1 | One-cycle commit success pulse |
| flash_commit | output | 1 | Tell the cache to make transactional lines normal |
| flash_abort | output | 1 | Tell the cache to discard transactional lines |
| status_word | output | ST_W | Modelled transaction status word |

## Verification
The assertions check on every cycle that an abort pulse lasts one cycle and never coincides with a commit pulse. They also check that an abort carries the flash-discard command and leaves no tags behind, that an invalidation of a tagged line in TX_OPEN always aborts, that an invalidation of an untagged line alone never does, and that a successful commit leaves the swapped value in the status word. Only the bench's scenarios can show the rest. That covers the handler address that reaches `abort_pc`, releases of untagged lines and requests in TX_IDLE having no effect, and the priority among simultaneous causes. The bench checks these against a reference model under directed and random traffic.

// File: rtl/abort_watch_pkg.sv
package abort_watch_pkg;
    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_OPEN = 1'b1
    } txn_state_e;
endpackage

// File: rtl/abort_watch_tags.sv
module abort_watch_tags #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             clr_all,
    input  logic             set_v,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             rel_v,
    input  logic [IDX_W-1:0] rel_idx,
    input  logic [IDX_W-1:0] probe_a_idx,
    input  logic [IDX_W-1:0] probe_b_idx,
    output logic             probe_a,
    output logic             probe_b,
    output logic [LINES-1:0] tags
);
    for (genvar g = 0; g < LINES; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                tags[g] <= 1'b0;
            end else if (upd_en) begin
                if (set_v && set_idx == IDX_W'(g)) begin
                    tags[g] <= 1'b1;
                end else if (rel_v && rel_idx == IDX_W'(g)) begin
                    tags[g] <= 1'b0;
                end
            end
        end
    end

    assign probe_a = tags[probe_a_idx];
    assign probe_b = tags[probe_b_idx];
endmodule

// File: rtl/abort_watch_status.sv
module abort_watch_status #(
    parameter int              ST_W       = 8,
    parameter logic [ST_W-1:0] ST_ACTIVE  = 1,
    parameter logic [ST_W-1:0] ST_ABORTED = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_active,
    input  logic            load_abort,
    input  logic            load_new,
    input  logic [ST_W-1:0] new_val,
    input  logic [ST_W-1:0] cmp_val,
    output logic            match,
    output logic [ST_W-1:0] word_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_abort) begin
            word_q <= ST_ABORTED;
        end else if (load_new) begin
            word_q <= new_val;
        end else if (load_active) begin
            word_q <= ST_ACTIVE;
        end
    end

    assign match = (word_q == cmp_val);
endmodule

// File: rtl/abort_watch_unit.sv
module abort_watch_unit
    import abort_watch_pkg::*;
#(
    parameter int              LINES      = 16,
    parameter int              PC_W       = 32,
    parameter int              ST_W       = 8,
    parameter logic [ST_W-1:0] ST_ACTIVE  = 1,
    parameter logic [ST_W-1:0] ST_ABORTED = 2,
    localparam int             IDX_W      = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_valid,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic             release_valid,
    input  logic [IDX_W-1:0] release_idx,
    input  logic             set_handler,
    input  logic [PC_W-1:0]  handler_pc,
    input  logic             inval_valid,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             self_abort,
    input  logic             commit_req,
    input  logic [ST_W-1:0]  commit_cmp,
    input  logic [ST_W-1:0]  commit_new,
    output logic             abort_valid,
    output logic [PC_W-1:0]  abort_pc,
    output logic             commit_ok,
    output logic             flash_commit,
    output logic             flash_abort,
    output logic [ST_W-1:0]  status_word
);
    txn_state_e       state_q, state_d;
    logic [PC_W-1:0]  handler_q;
    logic [LINES-1:0] tags_q;
    logic             hit_inval, hit_evict, cmp_match;
    logic             txn_open, start_now, abort_now, commit_now, tag_upd;

    assign txn_open  = (state_q == TX_OPEN);
    assign start_now = !txn_open && set_handler;
    assign abort_now = txn_open &&
                       (self_abort ||
                        (inval_valid && hit_inval) ||
                        (evict_valid && hit_evict) ||
                        (commit_req && !cmp_match));
    assign commit_now = txn_open && commit_req && !abort_now;
    assign tag_upd    = txn_open && !abort_now && !commit_now;

    abort_watch_tags #(.LINES(LINES)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (tag_upd),
        .clr_all     (abort_now || commit_now),
        .set_v       (mark_valid),
        .set_idx     (mark_idx),
        .rel_v       (release_valid),
        .rel_idx     (release_idx),
        .probe_a_idx (inval_idx),
        .probe_b_idx (evict_idx),
        .probe_a     (hit_inval),
        .probe_b     (hit_evict),
        .tags        (tags_q)
    );

    abort_watch_status #(
        .ST_W       (ST_W),
        .ST_ACTIVE  (ST_ACTIVE),
        .ST_ABORTED (ST_ABORTED)
    ) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_active (start_now),
        .load_abort  (abort_now),
        .load_new    (commit_now),
        .new_val     (commit_new),
        .cmp_val     (commit_cmp),
        .match       (cmp_match),
        .word_q      (status_word)
    );

    // Next-state logic: START, ABORT, COMMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start_now) state_d = TX_OPEN;
            TX_OPEN: if (abort_now || commit_now) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and handler address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q    <= '0;
            abort_valid  <= 1'b0;
            abort_pc     <= '0;
            commit_ok    <= 1'b0;
            flash_commit <= 1'b0;
            flash_abort  <= 1'b0;
        end else begin
            abort_valid  <= abort_now;
            flash_abort  <= abort_now;
            commit_ok    <= commit_now;
            flash_commit <= commit_now;
            if (abort_now) abort_pc <= handler_q;
            if (start_now || (tag_upd && set_handler)) handler_q <= handler_pc;
        end
    end
endmodule

// File: rtl/abort_watch_chk.sv
module abort_watch_chk #(
    parameter int LINES = 16,
    parameter int ST_W  = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txn_open,
    input logic [LINES-1:0] tags_q,
    input logic             inval_valid,
    input logic [IDX_W-1:0] inval_idx,
    input logic             evict_valid,
    input logic             self_abort,
    input logic             commit_req,
    input logic [ST_W-1:0]  commit_new,
    input logic             abort_valid,
    input logic             commit_ok,
    input logic             flash_abort,
    input logic             flash_commit,
    input logic [ST_W-1:0]  status_word
);
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |=> !abort_valid); // R10
    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_valid && commit_ok)); // R11
    AST_ABORT_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> (flash_abort && !flash_commit && tags_q == '0)); // R10
    AST_TAGGED_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_open && inval_valid && tags_q[inval_idx]) |=> abort_valid); // R4
    AST_UNTAGGED_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_open && inval_valid && !tags_q[inval_idx] && !evict_valid &&
         !self_abort && !commit_req) |=> !abort_valid); // R6
    AST_COMMIT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> (status_word == $past(commit_new) && flash_commit && tags_q == '0)); // R8
endmodule

bind abort_watch_unit abort_watch_chk #(.LINES(LINES), .ST_W(ST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_open     (txn_open),
    .tags_q       (tags_q),
    .inval_valid  (inval_valid),
    .inval_idx    (inval_idx),
    .evict_valid  (evict_valid),
    .self_abort   (self_abort),
    .commit_req   (commit_req),
    .commit_new   (commit_new),
    .abort_valid  (abort_valid),
    .commit_ok    (commit_ok),
    .flash_abort  (flash_abort),
    .flash_commit (flash_commit),
    .status_word  (status_word)
);

// File: tb/abort_watch_unit_test.sv
module abort_watch_unit_test;
    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);
    localparam int PC_W  = 32;
    localparam int ST_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mark_valid = 0, release_valid = 0, set_handler = 0;
    logic             inval_valid = 0, evict_valid = 0, self_abort = 0, commit_req = 0;
    logic [IDX_W-1:0] mark_idx = 0, release_idx = 0, inval_idx = 0, evict_idx = 0;
    logic [PC_W-1:0]  handler_pc = 0;
    logic [ST_W-1:0]  commit_cmp = 0, commit_new = 0;
    logic             abort_valid, commit_ok, flash_commit, flash_abort;
    logic [PC_W-1:0]  abort_pc;
    logic [ST_W-1:0]  status_word;

    int total = 0, bad = 0;
    bit finished = 0;

    // reference model state
    bit              m_open;
    bit [LINES-1:0]  m_tags;
    bit [PC_W-1:0]   m_handler;
    bit [ST_W-1:0]   m_status;
    bit              e_ab, e_ok;
    bit [PC_W-1:0]   e_pc;

    always #5 clk = ~clk;

    abort_watch_unit uut (.*);

    task automatic check(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mark_valid = 0; release_valid = 0; set_handler = 0;
        inval_valid = 0; evict_valid = 0; self_abort = 0; commit_req = 0;
    endtask

    function automatic string pick_tag(bit sa, bit hi, bit he, bit fail, bit ok, string dflt);
        if (sa && (hi || he || fail)) return "R11";
        if (sa)   return "R7";
        if (hi)   return "R4";
        if (he)   return "R5";
        if (fail) return "R9";
        if (ok)   return "R8";
        return dflt;
    endfunction

    // One clock: model prediction, edge, then compare at the ports.
    task automatic step(string dflt);
        bit hi, he, fail, ab, ok;
        string tag;
        hi   = m_open && inval_valid && m_tags[inval_idx];
        he   = m_open && evict_valid && m_tags[evict_idx];
        fail = m_open && commit_req && (m_status != commit_cmp);
        ab   = m_open && (self_abort || hi || he || fail);
        ok   = m_open && commit_req && !ab;
        e_ab = ab; e_ok = ok; e_pc = m_handler;
        tag  = pick_tag(m_open && self_abort, hi, he, fail, ok, dflt);
        if (ab) begin
            m_tags = '0; m_status = 8'h02; m_open = 0;
        end else if (ok) begin
            m_tags = '0; m_status = commit_new; m_open = 0;
        end else if (m_open) begin
            if (release_valid) m_tags[release_idx] = 1'b0;
            if (mark_valid)    m_tags[mark_idx] = 1'b1;
            if (set_handler)   m_handler = handler_pc;
        end else if (set_handler) begin
            m_handler = handler_pc; m_status = 8'h01; m_open = 1;
        end
        @(posedge clk); #1;
        check(tag, "abort_valid", abort_valid, e_ab);
        check(tag, "flash_abort", flash_abort, e_ab);
        check(tag, "commit_ok", commit_ok, e_ok);
        check(tag, "flash_commit", flash_commit, e_ok);
        check(tag, "status_word", status_word, m_status);
        if (e_ab) check("R10", "abort_pc", abort_pc, e_pc);
        idle_inputs();
    endtask

    task automatic start(logic [PC_W-1:0] pc);
        set_handler = 1; handler_pc = pc; step("R2");
    endtask

    initial begin
        #200000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_open = 0; m_tags = '0; m_handler = '0; m_status = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        check("R1", "abort_valid", abort_valid, 0);
        check("R1", "commit_ok", commit_ok, 0);
        check("R1", "flash_abort", flash_abort | flash_commit, 0);
        check("R1", "status_word", status_word, 0);
        step("R1");

        // R12 and R7: requests in TX_IDLE ignored
        commit_req = 1; commit_cmp = 0; commit_new = 8'h55; step("R12");
        self_abort = 1; step("R7");
        // R3: mark in TX_IDLE ignored, then invalidation must not abort
        mark_valid = 1; mark_idx = 4; step("R3");
        start(32'h1000_0040);
        inval_valid = 1; inval_idx = 4; step("R3");
        // R3/R6: release of untagged line, then invalidate it
        mark_valid = 1; mark_idx = 3; step("R3");
        release_valid = 1; release_idx = 5; step("R3");
        inval_valid = 1; inval_idx = 5; evict_valid = 1; evict_idx = 9; step("R6");
        // R2: handler update inside transaction
        set_handler = 1; handler_pc = 32'h2000_0080; step("R2");
        // R4: tagged invalidation aborts with latest handler
        inval_valid = 1; inval_idx = 3; step("R4");
        step("R10");
        // R5: eviction of tagged line
        start(32'h3000_0000);
        mark_valid = 1; mark_idx = 15; release_valid = 1; release_idx = 15; step("R3");
        evict_valid = 1; evict_idx = 15; step("R5");
        // R8: successful commit
        start(32'h4000_0000);
        mark_valid = 1; mark_idx = 7; step("R3");
        commit_req = 1; commit_cmp = 8'h01; commit_new = 8'h03; step("R8");
        inval_valid = 1; inval_idx = 7; step("R8");
        // R9: failed compare
        start(32'h5000_0000);
        commit_req = 1; commit_cmp = 8'h07; commit_new = 8'h03; step("R9");
        // R11: every cause at once, commit would otherwise succeed
        start(32'h6000_0000);
        mark_valid = 1; mark_idx = 2; step("R3");
        self_abort = 1; inval_valid = 1; inval_idx = 2; evict_valid = 1; evict_idx = 2;
        commit_req = 1; commit_cmp = 8'h01; commit_new = 8'h09; step("R11");
        step("R10");

        // Random traffic with a fixed seed
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            mark_valid    = ($urandom % 3) == 0;
            mark_idx      = IDX_W'($urandom % 6);
            release_valid = ($urandom % 4) == 0;
            release_idx   = IDX_W'($urandom % 6);
            set_handler   = ($urandom % 6) == 0;
            handler_pc    = $urandom;
            inval_valid   = ($urandom % 8) == 0;
            inval_idx     = IDX_W'($urandom % 8);
            evict_valid   = ($urandom % 10) == 0;
            evict_idx     = IDX_W'($urandom % 8);
            self_abort    = ($urandom % 40) == 0;
            commit_req    = ($urandom % 15) == 0;
            commit_cmp    = (($urandom % 4) == 0) ? 8'h02 : 8'h01;
            commit_new    = 8'($urandom);
            step("R3");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule